// File: doc/BRIEF.md
# Outbound Region Address Translator

This block maps a 32-bit address from the on-chip bus onto a 64-bit PCIe memory address for outgoing requests. The internal window is cut into 32 regions of one shared size. A 2-bit size code picks 1, 2, 4 or 8 MB. The index field of the address and the boundary of the offset field both move with that code. Each region carries its own 64-bit target base, split into a low word and a high word, and its own enable bit.

Software programs the size code, the enable mask and the per-region bases through a small register port with a word address. The bus side then presents requests, each with a valid strobe, an address and a read/write flag. One cycle later the block returns either a translated address or an error flag. The translated address comes with a flag that marks it as fitting in 32 bits. Building packets, routing configuration or I/O traffic, and inbound translation are all handled elsewhere.

Top module: `ob_region_xlate`

## Requirements
- R1: After reset the size code is 0, every low and high base reads 0, the enable mask reads 0, and neither rsp_valid nor rsp_err is asserted.
- R2: The region index is address bits [24:20], [25:21], [26:22] or [27:23] for size codes 0, 1, 2 and 3.
- R3: The low 32 bits of the translated address take bits below 20+size from the request address, and bits from 20+size upward from the selected low base. The low base bits below 20+size take no part.
- R4: Bits [63:32] of the translated address equal the selected high base. rsp_is32 is 1 exactly when that high base is zero.
- R5: A request whose region has its enable bit clear gives rsp_err=1, rsp_valid=0 and rsp_addr=0.
- R6: Every request gets exactly one response (rsp_valid or rsp_err) in the following cycle. Without a request, both flags are 0 in the following cycle.
- R7: A register write in the same cycle as a request is not seen by that request. It applies only to later requests.
- R8: Register map on cfg_addr: 0x00 holds the size code in bits [1:0], with other bits reading 0. 0x01 holds the enable mask, where bit n enables region n. 0x20+n holds the low base of region n. 0x40+n holds the high base of region n. All other addresses read 0 and ignore writes. cfg_rdata follows cfg_addr combinationally.
- R9: rsp_write repeats the req_write of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Internal bus address |
| req_write | input | 1 | 1 for write request, 0 for read |
| rsp_valid | output | 1 | Translated address is valid |
| rsp_err | output | 1 | Request hit a disabled region |
| rsp_addr | output | 64 | Translated PCIe address |
| rsp_is32 | output | 1 | Translated address fits in 32 bits |
| rsp_write | output | 1 | Echo of the request direction |

## Verification
On every cycle the assertions check several properties. Valid and error are never asserted together, and each request gets exactly one of them on the next cycle. The low offset bits of a valid result match the request address at the size code then in force. The 32-bit flag agrees with the upper word, and an error carries a zero address. Other behaviour only shows up in the bench scenarios: which region a given address selects under each size code, the masking of low base bits, the bit positions in the register map, and a write in the same cycle as a request staying invisible to that request. For these the bench compares against its own model of the register file.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int ADDR_W    = 32;
  localparam int BASE_W    = 32;
  localparam int REGIONS   = 32;
  localparam int IDX_W     = $clog2(REGIONS);
  localparam int SIZE_W    = 2;
  localparam int MIN_SHIFT = 20;
  localparam int CFG_AW    = 7;

  // position of the lowest index bit for a given size code
  function automatic int idx_lsb(logic [SIZE_W-1:0] sz);
    return MIN_SHIFT + int'(sz);
  endfunction

  function automatic logic [IDX_W-1:0] region_idx(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] sh;
    sh = a >> idx_lsb(sz);
    return sh[IDX_W-1:0];
  endfunction

  // ones on the offset bits that the region size keeps from the request
  function automatic logic [ADDR_W-1:0] offset_mask(logic [SIZE_W-1:0] sz);
    return (ADDR_W'(1) << idx_lsb(sz)) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] merge_low(logic [BASE_W-1:0] lo, logic [ADDR_W-1:0] a,
                                                  logic [SIZE_W-1:0] sz);
    return (lo & ~offset_mask(sz)) | (a & offset_mask(sz));
  endfunction
endpackage

// File: rtl/ob_cfg_regs.sv
module ob_cfg_regs
  import ob_xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [SIZE_W-1:0]   size_code,
  output logic [REGIONS-1:0]  en_mask,
  output logic [BASE_W-1:0]   base_lo [REGIONS],
  output logic [BASE_W-1:0]   base_hi [REGIONS]
);
  localparam logic [1:0] GRP_CTRL = 2'd0;
  localparam logic [1:0] GRP_LO   = 2'd1;
  localparam logic [1:0] GRP_HI   = 2'd2;

  logic [1:0]       grp;
  logic [IDX_W-1:0] slot;
  assign grp  = cfg_addr[CFG_AW-1 -: 2];
  assign slot = cfg_addr[IDX_W-1:0];

  // named write events
  logic wr_size, wr_en;
  assign wr_size = cfg_we && grp == GRP_CTRL && slot == '0;
  assign wr_en   = cfg_we && grp == GRP_CTRL && slot == IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_code <= '0;
      en_mask   <= '0;
    end else begin
      if (wr_size) size_code <= cfg_wdata[SIZE_W-1:0];
      if (wr_en)   en_mask   <= cfg_wdata[REGIONS-1:0];
    end
  end

  for (genvar n = 0; n < REGIONS; n++) begin : g_region
    logic wr_lo, wr_hi;
    assign wr_lo = cfg_we && grp == GRP_LO && slot == IDX_W'(n);
    assign wr_hi = cfg_we && grp == GRP_HI && slot == IDX_W'(n);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_lo[n] <= '0;
        base_hi[n] <= '0;
      end else begin
        if (wr_lo) base_lo[n] <= cfg_wdata;
        if (wr_hi) base_hi[n] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (grp)
      GRP_CTRL: begin
        if (slot == '0)            cfg_rdata = 32'(size_code);
        else if (slot == IDX_W'(1)) cfg_rdata = 32'(en_mask);
      end
      GRP_LO:  cfg_rdata = base_lo[slot];
      GRP_HI:  cfg_rdata = base_hi[slot];
      default: cfg_rdata = '0;
    endcase
  end

  p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_size, wr_en}) <= 1);
endmodule

// File: rtl/ob_region_sel.sv
module ob_region_sel
  import ob_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SIZE_W-1:0]  size_code,
  input  logic [REGIONS-1:0] en_mask,
  input  logic [BASE_W-1:0]  base_lo [REGIONS],
  input  logic [BASE_W-1:0]  base_hi [REGIONS],
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_en,
  output logic [BASE_W-1:0]  sel_lo,
  output logic [BASE_W-1:0]  sel_hi
);
  assign sel_idx = region_idx(addr, size_code);
  assign sel_en  = en_mask[sel_idx];
  assign sel_lo  = base_lo[sel_idx];
  assign sel_hi  = base_hi[sel_idx];
endmodule

// File: rtl/ob_addr_merge.sv
module ob_addr_merge
  import ob_xlate_pkg::*;
(
  input  logic [BASE_W-1:0] sel_lo,
  input  logic [BASE_W-1:0] sel_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_code,
  output logic [63:0]       pcie_addr,
  output logic              fits32
);
  assign pcie_addr = {sel_hi, merge_low(sel_lo, addr, size_code)};
  assign fits32    = (sel_hi == '0);
endmodule

// File: rtl/ob_region_xlate.sv
module ob_region_xlate
  import ob_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [6:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [63:0] rsp_addr,
  output logic        rsp_is32,
  output logic        rsp_write
);
  logic [SIZE_W-1:0]  size_code;
  logic [REGIONS-1:0] en_mask;
  logic [BASE_W-1:0]  base_lo [REGIONS];
  logic [BASE_W-1:0]  base_hi [REGIONS];

  ob_cfg_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .size_code, .en_mask, .base_lo, .base_hi
  );

  logic [IDX_W-1:0]  sel_idx;
  logic              sel_en;
  logic [BASE_W-1:0] sel_lo, sel_hi;

  ob_region_sel u_sel (
    .addr(req_addr), .size_code, .en_mask, .base_lo, .base_hi,
    .sel_idx, .sel_en, .sel_lo, .sel_hi
  );

  logic [63:0] pcie_addr;
  logic        fits32;

  ob_addr_merge u_merge (
    .sel_lo, .sel_hi, .addr(req_addr), .size_code, .pcie_addr, .fits32
  );

  // named request events
  logic hit_ok, hit_off;
  assign hit_ok  = req_valid && sel_en;
  assign hit_off = req_valid && !sel_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_is32  <= 1'b0;
      rsp_write <= 1'b0;
    end else begin
      rsp_valid <= hit_ok;
      rsp_err   <= hit_off;
      rsp_addr  <= hit_ok ? pcie_addr : '0;
      rsp_is32  <= hit_ok && fits32;
      rsp_write <= req_valid && req_write;
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_err));
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_addr == '0);
  p_one_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid || rsp_err));
  p_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || rsp_err));
  p_is32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_is32 == (rsp_addr[63:32] == 32'd0)));
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !rsp_valid ||
      ((rsp_addr[31:0] & offset_mask($past(size_code))) ==
       ($past(req_addr) & offset_mask($past(size_code)))));
  p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_write == $past(req_write));
endmodule

// File: tb/ob_region_xlate_tb_top.sv
`timescale 1ns/1ps
module ob_region_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_err, rsp_is32, rsp_write;
  logic [63:0] rsp_addr;

  always #10 clk = ~clk; // 50 MHz

  ob_region_xlate dut_i (.*);

  int errors = 0;
  int checks = 0;

  // bench model of the programmable state
  logic [1:0]  m_size;
  logic [31:0] m_en;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];

  function automatic int b_idx(logic [31:0] a, logic [1:0] s);
    int sh = 20 + s;
    return int'((a / (32'd1 << sh)) % 32);
  endfunction

  function automatic logic [31:0] b_low(logic [31:0] base, logic [31:0] a, logic [1:0] s);
    logic [31:0] sz = 32'd1 << (20 + s);
    return (base - (base % sz)) + (a % sz);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [6:0] a, logic [31:0] d);
    if (a == 7'h00) m_size = d[1:0];
    else if (a == 7'h01) m_en = d;
    else if (a[6:5] == 2'b01) m_lo[a[4:0]] = d;
    else if (a[6:5] == 2'b10) m_hi[a[4:0]] = d;
  endtask

  function automatic logic [31:0] model_read(logic [6:0] a);
    if (a == 7'h00) return 32'(m_size);
    if (a == 7'h01) return m_en;
    if (a[6:5] == 2'b01) return m_lo[a[4:0]];
    if (a[6:5] == 2'b10) return m_hi[a[4:0]];
    return 32'd0;
  endfunction

  // one cycle: optional write and optional request; checks response
  task automatic step(bit we, logic [6:0] wa, logic [31:0] wd,
                      bit rv, logic [31:0] ra, bit rw, string tag);
    int i;
    bit e_ok;
    logic [63:0] e_addr;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    req_valid = rv; req_addr = ra; req_write = rw;
    i = b_idx(ra, m_size);
    e_ok = m_en[i];
    e_addr = e_ok ? {m_hi[i], b_low(m_lo[i], ra, m_size)} : 64'd0;
    @(posedge clk);
    if (we) model_write(wa, wd);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk({tag, " R6 valid"}, 64'(rsp_valid), 64'(rv && e_ok));
    chk({tag, " R5 err"},   64'(rsp_err),   64'(rv && !e_ok));
    if (rv) begin
      chk({tag, " R3 addr"}, rsp_addr, e_addr);
      chk({tag, " R4 is32"}, 64'(rsp_is32), 64'(e_ok && e_addr[63:32] == 0));
      chk({tag, " R9 dir"},  64'(rsp_write), 64'(rw));
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, 32'd0, 1'b0, "wr");
  endtask

  task automatic rd_chk(logic [6:0] a, string tag);
    cfg_addr = a;
    #1;
    chk(tag, 64'(cfg_rdata), 64'(model_read(a)));
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_size = 0; m_en = 0;
    for (int n = 0; n < 32; n++) begin m_lo[n] = 0; m_hi[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 rsp_err", 64'(rsp_err), 0);
    for (int a = 0; a < 128; a++) rd_chk(7'(a), "R1 R8 reset readback");
    // R5 disabled region after reset
    step(0, 0, 0, 1, 32'h0130_0000, 0, "R5 reset-disabled");

    // R2/R3: same address under each size code
    wr(7'h01, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) wr(7'(32 + n), 32'h8000_0000 | (n << 24) | 32'h000F_FFFF);
    for (int s = 0; s < 4; s++) begin
      wr(7'h00, 32'(s));
      rd_chk(7'h00, "R8 size readback");
      step(0, 0, 0, 1, 32'h0FAB_CDEF, 1, "R2 size sweep");
      step(0, 0, 0, 1, 32'h00F0_0001, 0, "R3 size sweep");
    end
    // R8: size field keeps only two bits, unmapped write ignored
    wr(7'h00, 32'hFFFF_FFF5);
    rd_chk(7'h00, "R8 size width");
    wr(7'h7F, 32'h1234_5678);
    rd_chk(7'h7F, "R8 unmapped");
    rd_chk(7'h02, "R8 unmapped ctrl");
    // R4: high base nonzero
    wr(7'h00, 0);
    wr(7'h45, 32'h0000_00A5);
    step(0, 0, 0, 1, 32'h0055_4321, 0, "R4 high base");
    // R5: disable region 5
    wr(7'h01, 32'hFFFF_FFDF);
    step(0, 0, 0, 1, 32'h0050_0000, 1, "R5 disabled");
    // R7: same-cycle enable and base writes
    step(1, 7'h01, 32'hFFFF_FFFF, 1, 32'h0050_0000, 0, "R7 enable same cycle");
    step(0, 0, 0, 1, 32'h0050_0000, 0, "R7 enable later");
    step(1, 7'h25, 32'h7770_0000, 1, 32'h0050_0010, 0, "R7 base same cycle");
    step(0, 0, 0, 1, 32'h0050_0010, 0, "R7 base later");
    step(1, 7'h00, 32'd3, 1, 32'h0780_0000, 0, "R7 size same cycle");
    step(0, 0, 0, 1, 32'h0780_0000, 0, "R7 size later");

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [6:0] wa;
      int sel = $urandom_range(0, 9);
      wa = (sel == 0) ? 7'h00 : (sel == 1) ? 7'h01 :
           (sel < 6) ? 7'(32 + $urandom_range(0, 31)) :
           (sel < 9) ? 7'(64 + $urandom_range(0, 31)) : 7'($urandom_range(96, 127));
      step(($urandom_range(0, 2) == 0), wa,
           (sel >= 6 && sel < 9 && $urandom_range(0, 1) == 0) ? 32'd0 : $urandom(),
           ($urandom_range(0, 3) != 0), $urandom(), 1'($urandom_range(0, 1)), "R2 R7 random");
      if (k % 8 == 0) rd_chk(wa, "R8 random readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule